// File: doc/BRIEF.md
# Ternary-step successive-approximation conversion controller

This block sequences one 10-bit successive-approximation conversion. The first four steps are coarse and ternary. Each of them turns the comparator's polarity bit and its late-decision flag into a digit of +1, 0 or −1. The last six steps are ordinary binary decisions. Each step raises a comparator strobe for a fixed number of clocks, and the width of that strobe is the time window that separates a prompt decision from a late one. One evaluate clock follows, in which the decision is taken in. A one-hot step ring selects the current step.

After a zero digit the block does not switch the capacitor array. When the leading step of a two-step coarse group resolves to zero, the second step of that group is skipped entirely, so a conversion runs 8, 9 or 10 steps. The final code is rebuilt by adding the weighted coarse digits to the binary tail, as a 1.5-bit-per-stage pipelined converter does. This addition needs no extra cycles. A done strobe marks the code, and a step counter reports how many steps ran.

States: `ST_IDLE` (waiting), `ST_STROBE` (comparator strobe high), `ST_EVAL` (decision taken, DAC command issued, ring advanced), `ST_FINISH` (code assembled). Transitions:
- IDLE→STROBE on `start`.
- STROBE→EVAL when the strobe counter reaches its last count.
- EVAL→STROBE when steps remain.
- EVAL→FINISH on the final step.
- FINISH→IDLE unconditionally.

Top module: `tsar_ctrl`

## Requirements
- R1: While reset is low and just after it, `busy`, `done`, `cmp_strobe`, `dac_dir`, `dac_sel`, `code` and `step_count` are all zero.
- R2: `start` is taken only in the idle state. A `start` pulse during a conversion changes neither its code, its step count nor its duration.
- R3: Every executed step holds `cmp_strobe` high for exactly STROBE_LEN (default 2) consecutive clocks, followed by one evaluate clock in which `cmp_pol` and `cmp_slow` are sampled. `cmp_strobe` is low whenever `busy` is low.
- R4: On coarse steps 0 to 3, `cmp_slow`=1 gives digit 0 (stored 2'b00). Otherwise `cmp_pol`=1 gives +1 (2'b01) and `cmp_pol`=0 gives −1 (2'b11).
- R5: Each executed step with a nonzero digit sets `dac_sel` to the one-hot bit of its step (bit k = step k) for exactly one clock, the clock after its evaluate clock, with `dac_dir` equal to the sampled `cmp_pol`. A zero digit produces no `dac_sel` pulse.
- R6: On binary steps 4 to 9 the stored bit is `cmp_pol`. `cmp_slow` is ignored and a `dac_sel` pulse is always issued.
- R7: A zero digit on step 0 skips step 1, and a zero digit on step 2 skips step 3. A skipped step contributes digit 0. `step_count` equals the number of steps executed (8 to 10).
- R8: `code` = saturate(480 + Σ d_k·2^(9−k) over steps k = 0..3 + B) to 0..1023, where B is the six binary bits with step 4 as the MSB.
- R9: `done` is high for exactly one clock, (STROBE_LEN+1)·steps + 2 clocks after the clock that samples `start`. `code` changes only with `done` and holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (idle only) |
| cmp_pol | input | 1 | Comparator polarity for the current step |
| cmp_slow | input | 1 | Decision arrived after the strobe window |
| cmp_strobe | output | 1 | Comparator strobe; its width is the time threshold |
| dac_sel | output | 10 | One-hot per-step capacitor switch command |
| dac_dir | output | 1 | Switch direction for the pulsed step |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock code-valid strobe |
| code | output | 10 | Corrected output code |
| step_count | output | 4 | Steps executed in the last conversion |

## Verification
The bench sweeps all 81 combinations of prompt-positive, prompt-negative and late decisions on the four coarse steps. Each combination runs with three binary tails, which separates the skip pattern, the digit weights and both saturation limits. A full sweep of the 64 binary tails runs behind all-zero coarse digits, which isolates the binary bit order and shows that the late flag on binary steps has no effect. One run pulses `start` mid-conversion to show that it is ignored. For every run the bench recomputes the code, the step count, the duration, the strobe widths and the per-step switch commands.

// File: rtl/tsar_pkg.sv
package tsar_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b11
    } tdig_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_EVAL,
        ST_FINISH
    } ctl_state_t;

    // A late decision means the input sits near the middle of the range.
    function automatic tdig_t resolve_digit(input logic slow, input logic pol);
        if (slow) return DIG_ZERO;
        return pol ? DIG_POS : DIG_NEG;
    endfunction

endpackage

// File: rtl/tsar_ring.sv
module tsar_ring #(
    parameter int NSTEP     = 10,
    parameter int NUM_TERN  = 4,
    parameter int GROUP_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic             skip,
    output logic [NSTEP-1:0] ring_q,
    output logic             is_last,
    output logic             is_tern,
    output logic             is_lead
);

    function automatic logic [NSTEP-1:0] mk_lead();
        logic [NSTEP-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_TERN; k++)
            if (k % GROUP_LEN == 0) m[k] = 1'b1;
        return m;
    endfunction

    function automatic logic [NSTEP-1:0] mk_tern();
        logic [NSTEP-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_TERN; k++) m[k] = 1'b1;
        return m;
    endfunction

    localparam logic [NSTEP-1:0] LEAD_MASK = mk_lead();
    localparam logic [NSTEP-1:0] TERN_MASK = mk_tern();

    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_q <= '0;
        else if (load)
            ring_q <= NSTEP'(1);
        else if (adv && skip)
            ring_q <= {ring_q[NSTEP-3:0], 2'b00};
        else if (adv)
            ring_q <= {ring_q[NSTEP-2:0], 1'b0};
    end

    assign is_last = ring_q[NSTEP-1];
    assign is_tern = |(ring_q & TERN_MASK);
    assign is_lead = |(ring_q & LEAD_MASK);

endmodule

// File: rtl/tsar_digit_store.sv
module tsar_digit_store
    import tsar_pkg::*;
#(
    parameter int NSTEP    = 10,
    parameter int NUM_TERN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [NSTEP-1:0]          ring,
    input  tdig_t                     digit,
    input  logic                      bit_in,
    output logic [2*NUM_TERN-1:0]     tern_q,
    output logic [NSTEP-NUM_TERN-1:0] bin_q
);

    localparam int NBIN = NSTEP - NUM_TERN;

    for (genvar i = 0; i < NUM_TERN; i++) begin : g_tern
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                tern_q[2*i +: 2] <= DIG_ZERO;
            else if (wr_en && ring[i])
                tern_q[2*i +: 2] <= digit;
        end
    end

    // The first binary step lands in the most significant binary bit.
    for (genvar j = 0; j < NBIN; j++) begin : g_bin
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                bin_q[NBIN-1-j] <= 1'b0;
            else if (wr_en && ring[NUM_TERN+j])
                bin_q[NBIN-1-j] <= bit_in;
        end
    end

endmodule

// File: rtl/tsar_recon.sv
module tsar_recon
    import tsar_pkg::*;
#(
    parameter int RES      = 10,
    parameter int NUM_TERN = 4
) (
    input  logic [2*NUM_TERN-1:0]   tern_q,
    input  logic [RES-NUM_TERN-1:0] bin_q,
    output logic [RES-1:0]          code
);

    localparam int OFFSET = (1 << (RES-1)) - (1 << (RES-1-NUM_TERN));
    localparam int MAXV   = (1 << RES) - 1;

    int acc;

    always_comb begin
        acc = OFFSET + int'(bin_q);
        for (int k = 0; k < NUM_TERN; k++) begin
            case (tdig_t'(tern_q[2*k +: 2]))
                DIG_POS: acc = acc + (1 << (RES-1-k));
                DIG_NEG: acc = acc - (1 << (RES-1-k));
                default: ;
            endcase
        end
        if (acc < 0)
            code = '0;
        else if (acc > MAXV)
            code = '1;
        else
            code = acc[RES-1:0];
    end

endmodule

// File: rtl/tsar_ctrl.sv
module tsar_ctrl
    import tsar_pkg::*;
#(
    parameter int RES        = 10,
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_LEN  = 2,
    parameter int STROBE_LEN = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       cmp_pol,
    input  logic                       cmp_slow,
    output logic                       cmp_strobe,
    output logic [RES-1:0]             dac_sel,
    output logic                       dac_dir,
    output logic                       busy,
    output logic                       done,
    output logic [RES-1:0]             code,
    output logic [$clog2(RES+1)-1:0]   step_count
);

    localparam int NUM_TERN = NUM_GROUPS * GROUP_LEN;
    localparam int CNT_W    = $clog2(RES+1);
    localparam int SCW      = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;

    ctl_state_t state_q, state_d;
    logic [SCW-1:0]   stb_cnt_q;
    logic [RES-1:0]   ring;
    logic             is_last, is_tern, is_lead;
    logic             load, in_eval, stb_last, skip, switch_now;
    tdig_t            cur_digit;
    logic [2*NUM_TERN-1:0]   tern_q;
    logic [RES-NUM_TERN-1:0] bin_q;
    logic [RES-1:0]   recon_code;
    logic [RES-1:0]   dac_sel_q, code_q;
    logic             dac_dir_q, done_q;
    logic [CNT_W-1:0] step_count_q;

    assign load       = (state_q == ST_IDLE) && start;
    assign in_eval    = (state_q == ST_EVAL);
    assign stb_last   = (stb_cnt_q == SCW'(STROBE_LEN-1));
    assign cur_digit  = resolve_digit(cmp_slow, cmp_pol);
    assign skip       = is_lead && (cur_digit == DIG_ZERO);
    assign switch_now = !is_tern || (cur_digit != DIG_ZERO);

    tsar_ring #(
        .NSTEP    (RES),
        .NUM_TERN (NUM_TERN),
        .GROUP_LEN(GROUP_LEN)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (in_eval && !is_last),
        .skip   (skip),
        .ring_q (ring),
        .is_last(is_last),
        .is_tern(is_tern),
        .is_lead(is_lead)
    );

    tsar_digit_store #(
        .NSTEP   (RES),
        .NUM_TERN(NUM_TERN)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .wr_en (in_eval),
        .ring  (ring),
        .digit (cur_digit),
        .bit_in(cmp_pol),
        .tern_q(tern_q),
        .bin_q (bin_q)
    );

    tsar_recon #(
        .RES     (RES),
        .NUM_TERN(NUM_TERN)
    ) u_recon (
        .tern_q(tern_q),
        .bin_q (bin_q),
        .code  (recon_code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STROBE;
            ST_STROBE: if (stb_last) state_d = ST_EVAL;
            ST_EVAL:   state_d = is_last ? ST_FINISH : ST_STROBE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and per-step datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_cnt_q    <= '0;
            dac_sel_q    <= '0;
            dac_dir_q    <= 1'b0;
            done_q       <= 1'b0;
            code_q       <= '0;
            step_count_q <= '0;
        end else begin
            done_q    <= 1'b0;
            dac_sel_q <= '0;
            if (load) begin
                stb_cnt_q    <= '0;
                step_count_q <= '0;
            end
            if (state_q == ST_STROBE)
                stb_cnt_q <= stb_last ? '0 : stb_cnt_q + SCW'(1);
            if (in_eval) begin
                step_count_q <= step_count_q + CNT_W'(1);
                if (switch_now) begin
                    dac_sel_q <= ring;
                    dac_dir_q <= cmp_pol;
                end
            end
            if (state_q == ST_FINISH) begin
                code_q <= recon_code;
                done_q <= 1'b1;
            end
        end
    end

    assign cmp_strobe = (state_q == ST_STROBE);
    assign busy       = (state_q != ST_IDLE);
    assign dac_sel    = dac_sel_q;
    assign dac_dir    = dac_dir_q;
    assign done       = done_q;
    assign code       = code_q;
    assign step_count = step_count_q;

endmodule

// File: rtl/tsar_ctrl_chk.sv
module tsar_ctrl_chk #(
    parameter int RES        = 10,
    parameter int NUM_GROUPS = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     done,
    input logic                     cmp_strobe,
    input logic [RES-1:0]           dac_sel,
    input logic [RES-1:0]           code,
    input logic [$clog2(RES+1)-1:0] step_count
);

    localparam int CNT_W = $clog2(RES+1);

    AST_DAC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_sel)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmp_strobe && dac_sel == '0)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(code)); // R9

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (step_count >= CNT_W'(RES - NUM_GROUPS) && step_count <= CNT_W'(RES))); // R7

endmodule

bind tsar_ctrl tsar_ctrl_chk #(
    .RES       (RES),
    .NUM_GROUPS(NUM_GROUPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmp_strobe(cmp_strobe),
    .dac_sel   (dac_sel),
    .code      (code),
    .step_count(step_count)
);

// File: tb/tsar_ctrl_tb.sv
module tsar_ctrl_tb;

    localparam int RES    = 10;
    localparam int STROBE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_pol = 1'b0;
    logic cmp_slow = 1'b0;
    logic cmp_strobe, dac_dir, busy, done;
    logic [RES-1:0] dac_sel, code;
    logic [3:0] step_count;

    int n_tests = 0;
    int n_fail  = 0;
    int total_cyc = 0;

    always #2.5 clk = ~clk;

    tsar_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_pol   (cmp_pol),
        .cmp_slow  (cmp_slow),
        .cmp_strobe(cmp_strobe),
        .dac_sel   (dac_sel),
        .dac_dir   (dac_dir),
        .busy      (busy),
        .done      (done),
        .code      (code),
        .step_count(step_count)
    );

    always @(posedge clk) begin
        total_cyc <= total_cyc + 1;
        if (total_cyc == 180000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 180000 cycles", total_cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // c[k]: 0 = late decision, 1 = prompt positive, 2 = prompt negative
    task automatic run_conv(input int c[4], input int bval, input bit poke);
        bit exec[RES];
        bit pol[RES];
        bit slow[RES];
        int d[4];
        int steps, raw, expc, cyc, idx, run, pulses, dir_bad, strobe_bad, exp_pulses;
        int exp_mask, got_mask;
        bit prev, got_done;
        for (int k = 0; k < RES; k++) exec[k] = 1'b1;
        if (c[0] == 0) exec[1] = 1'b0;
        if (c[2] == 0) exec[3] = 1'b0;
        steps = 0; exp_mask = 0; exp_pulses = 0;
        for (int k = 0; k < RES; k++) begin
            if (k < 4) begin
                slow[k] = (c[k] == 0);
                pol[k]  = (c[k] == 1) ? 1'b1 : (c[k] == 2) ? 1'b0 : k[0];
                d[k]    = !exec[k] ? 0 : (c[k] == 1) ? 1 : (c[k] == 2) ? -1 : 0;
            end else begin
                pol[k]  = bit'((bval >> (RES-1-k)) & 1);
                slow[k] = ((bval + k) % 3 == 0);
            end
            if (exec[k]) begin
                steps++;
                if (k >= 4 || d[k] != 0) begin
                    exp_mask |= (1 << k);
                    exp_pulses++;
                end
            end
        end
        raw = 480 + 512*d[0] + 256*d[1] + 128*d[2] + 64*d[3] + bval;
        expc = (raw < 0) ? 0 : (raw > 1023) ? 1023 : raw;

        @(negedge clk);
        start = 1'b1;
        cyc = 0; idx = 0; run = 0; pulses = 0; dir_bad = 0; strobe_bad = 0;
        got_mask = 0; prev = 1'b0; got_done = 1'b0;
        while (!got_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 7) start = 1'b1;
            if (poke && cyc == 8) start = 1'b0;
            if (cmp_strobe && !prev) begin
                if (idx < RES) begin
                    cmp_pol  = pol[idx];
                    cmp_slow = slow[idx];
                end
                if ((idx == 0 || idx == 2) && c[idx] == 0) idx += 2;
                else idx++;
                run = 1;
            end else if (cmp_strobe) begin
                run++;
            end
            if (!cmp_strobe && prev && run != STROBE) strobe_bad++;
            if (dac_sel != '0) begin
                pulses++;
                got_mask |= int'(dac_sel);
                for (int k = 0; k < RES; k++)
                    if (dac_sel[k] && dac_dir != pol[k]) dir_bad++;
            end
            prev = cmp_strobe;
            if (done) got_done = 1'b1;
        end
        check(got_done, "R9", "done seen", int'(got_done), 1);
        check(cyc == (STROBE+1)*steps + 2, "R9", "done latency", cyc, (STROBE+1)*steps + 2);
        check(code == expc, "R8", "code", int'(code), expc);
        check(int'(step_count) == steps, "R7", "step_count", int'(step_count), steps);
        check(got_mask == exp_mask, "R5", "dac_sel mask", got_mask, exp_mask);
        check(pulses == exp_pulses, "R6", "dac pulse count", pulses, exp_pulses);
        check(dir_bad == 0, "R5", "dac_dir mismatches", dir_bad, 0);
        check(strobe_bad == 0, "R3", "strobe width errors", strobe_bad, 0);
        check(!busy, "R2", "busy at done", int'(busy), 0);
        @(negedge clk);
        check(!done, "R9", "done width", int'(done), 0);
        repeat (3) @(negedge clk);
        check(code == expc && !busy, "R9", "code held", int'(code), expc);
    endtask

    initial begin
        int c[4];
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !cmp_strobe && !dac_dir && dac_sel == '0 && code == '0
              && step_count == '0, "R1", "outputs in reset", int'(code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmp_strobe && dac_sel == '0 && code == '0,
              "R1", "outputs after reset", int'(busy), 0);

        // R4, R7, R8: every coarse decision pattern with three binary tails
        for (int t = 0; t < 81; t++) begin
            for (int v = 0; v < 3; v++) begin
                int b;
                b = (v == 0) ? 0 : (v == 1) ? 63 : (t * 7) % 64;
                c[0] = t % 3; c[1] = (t / 3) % 3; c[2] = (t / 9) % 3; c[3] = (t / 27) % 3;
                run_conv(c, b, 1'b0);
            end
        end

        // R6: all binary tails behind zero coarse digits (late flag varies)
        for (int b = 0; b < 64; b++) begin
            c[0] = 0; c[1] = 1; c[2] = 0; c[3] = 2;
            run_conv(c, b, 1'b0);
        end

        // R2: start pulsed mid-conversion is ignored
        c[0] = 1; c[1] = 2; c[2] = 0; c[3] = 1;
        run_conv(c, 37, 1'b1);
        c[0] = 2; c[1] = 1; c[2] = 1; c[3] = 0;
        run_conv(c, 5, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule